// File: doc/BRIEF.md
# Converter Serial Readout Port with Early Abort

This block is the device side of the serial port of a multi-channel data converter, written as a synchronous digital slave. A host drives an active-low chip select, a serial clock and a serial data input. The block drives serial data out together with an output-enable that stands for the high-impedance state. While the port shifts out a 32-bit result word, it also captures a 13-bit configuration word from the input line. That word selects speed, resolution and channel for the next conversion. The conversion itself is a stub: it stays busy for a fixed number of system clocks and then latches a test value taken from an input bus.

The port moves through three named states in a fixed order. In CONVERT the stub is busy. SLEEP means a result is waiting. READOUT means the word is being shifted. The transitions are named as follows:
- conv_done (CONVERT to SLEEP): the stub's count expires.
- select (SLEEP to READOUT): chip select is low.
- abort (READOUT to CONVERT): chip select rises.
- word_end (READOUT to CONVERT): the 32nd falling serial-clock edge.

The abort and word_end transitions both start a new conversion at once. Whether the configuration captured so far is kept depends on how far the readout had got.

Serial inputs are resynchronised to the system clock. Input bits are taken on rising serial-clock edges, and output bits advance on falling edges.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the port is in CONVERT, `busy` is 1, `sdo_oe` is 0 and `cfg_out` holds the reset configuration (all zeros by default).
- R2: `sdo_oe` is 0 whenever chip select is high and 1 whenever it is low.
- R3: While a conversion runs, `busy` is 1 for exactly CONV_CYCLES system clocks, and with chip select low `sdo` reads 1 (end-of-conversion flag, 1 = not ready).
- R4: In READOUT the word appears MSB first: bit 31 = 0 (ready flag), bit 30 = 0, bits 29..0 = the converted value. Bit 31 is present before the first falling serial-clock edge, and each falling edge brings up the next lower bit.
- R5: A rising chip select in READOUT, at any bit position, ends the readout and starts a new conversion (`busy` returns to 1).
- R6: The first 13 `sdi` bits, taken MSB first on rising serial-clock edges, become `cfg_out` when the readout ends after at least 13 rising and at least 14 falling serial-clock edges.
- R7: A readout that ends after fewer than 14 falling edges (for example 5, or exactly 13) leaves `cfg_out` unchanged.
- R8: After the 32nd falling edge with chip select still low, the port commits the configuration, starts a new conversion and shows `sdo` = 1.
- R9: The order is CONVERT, then SLEEP, then READOUT. The converted value is captured when the conversion ends, and the port waits in SLEEP with `busy` at 0 for as long as chip select stays high. If chip select is already low at that point, `sdo` falls from 1 to 0 to mark readiness.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host, idles low |
| sdi | input | 1 | Serial configuration input |
| conv_data | input | 30 | Test value latched by the conversion stub at its end |
| sdo | output | 1 | Serial data / conversion status output |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 stands for high impedance |
| busy | output | 1 | High while a conversion is in progress |
| cfg_out | output | 13 | Configuration applied to the current conversion |

## Verification
The bench aims at the commit boundary. It aborts after exactly 13 serial clocks and after exactly 14. A port that counted rising edges only, or that stopped one edge off, would keep the configuration in the first case or lose it in the second. A 5-bit abort checks that a new conversion starts at once and lasts the full busy period; a port that waited for the whole word would leave `busy` low.

A full 32-bit read checks that the port turns itself around on the last falling edge even while chip select stays low. A port that did not would keep showing 0 instead of the busy flag. The conversion input is also changed while the port sleeps, so a port that sampled it at readout instead of at the end of conversion returns the wrong word. A further test polls with chip select held low through a whole conversion and then reads the word without ever raising it.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_DOUT  = 2'd2
    } sp_state_e;

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic cs_low,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s
);

    logic [STAGES:0] cs_p;
    logic [STAGES:0] sck_p;
    logic [STAGES:0] sdi_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_p  <= '1;
            sck_p <= '0;
            sdi_p <= '0;
        end else begin
            cs_p  <= {cs_p[STAGES-1:0], cs_n};
            sck_p <= {sck_p[STAGES-1:0], sck};
            sdi_p <= {sdi_p[STAGES-1:0], sdi};
        end
    end

    assign cs_low   = ~cs_p[STAGES-1];
    assign cs_rise  = cs_p[STAGES-1] & ~cs_p[STAGES];
    assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
    assign sdi_s    = sdi_p[STAGES-1];

endmodule

// File: rtl/adc_sp_conv.sv
module adc_sp_conv #(
    parameter int DATA_W      = 30,
    parameter int CONV_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] conv_data,
    output logic              busy,
    output logic              finish,
    output logic [DATA_W-1:0] result
);

    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // High in the final busy cycle; the port leaves CONVERT on the same edge
    assign finish = busy && (cnt == LAST) && !start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b1;
            cnt    <= '0;
            result <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy   <= 1'b0;
                result <= conv_data;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_sp_shift.sv
module adc_sp_shift #(
    parameter int WORD_W = 32,
    parameter int CFG_W  = 13,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              active,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi,
    output logic              sdo_bit,
    output logic [CFG_W-1:0]  cap,
    output logic [CNT_W-1:0]  rise_cnt,
    output logic [CNT_W-1:0]  fall_cnt
);

    localparam logic [CNT_W-1:0] CAP_LIM  = CNT_W'(CFG_W);
    localparam logic [CNT_W-1:0] WORD_LIM = CNT_W'(WORD_W);

    logic [WORD_W-1:0] out_sr;

    assign sdo_bit = out_sr[WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_sr   <= '0;
            cap      <= '0;
            rise_cnt <= '0;
            fall_cnt <= '0;
        end else if (load) begin
            out_sr   <= load_word;
            cap      <= '0;
            rise_cnt <= '0;
            fall_cnt <= '0;
        end else if (active) begin
            if (sck_rise) begin
                if (rise_cnt < CAP_LIM)
                    cap <= {cap[CFG_W-2:0], sdi};
                if (rise_cnt < WORD_LIM)
                    rise_cnt <= rise_cnt + 1'b1;
            end
            if (sck_fall) begin
                out_sr <= {out_sr[WORD_W-2:0], 1'b0};
                if (fall_cnt < WORD_LIM)
                    fall_cnt <= fall_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
    parameter int              WORD_W      = 32,
    parameter int              CFG_W       = 13,
    parameter int              CONV_CYCLES = 64,
    parameter int              SYNC_STAGES = 2,
    parameter logic [CFG_W-1:0] CFG_RESET  = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sck,
    input  logic                sdi,
    input  logic [WORD_W-3:0]   conv_data,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                busy,
    output logic [CFG_W-1:0]    cfg_out
);
    import adc_sp_pkg::*;

    localparam int DATA_W = WORD_W - 2;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] RISE_NEED = CNT_W'(CFG_W);
    localparam logic [CNT_W-1:0] FALL_NEED = CNT_W'(CFG_W + 1);
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(WORD_W - 1);

    sp_state_e         state_q, state_d;
    logic              cs_low, cs_rise, sck_rise, sck_fall, sdi_s;
    logic              start, finish, load, commit;
    logic [DATA_W-1:0] result;
    logic              sdo_bit;
    logic [CFG_W-1:0]  cap;
    logic [CFG_W-1:0]  cfg_q;
    logic [CNT_W-1:0]  rise_cnt, fall_cnt;

    adc_sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .cs_low(cs_low), .cs_rise(cs_rise), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .sdi_s(sdi_s)
    );

    adc_sp_conv #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk(clk), .rst_n(rst_n), .start(start), .conv_data(conv_data),
        .busy(busy), .finish(finish), .result(result)
    );

    adc_sp_shift #(.WORD_W(WORD_W), .CFG_W(CFG_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_word({1'b0, 1'b0, result}),
        .active(state_q == ST_DOUT),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi(sdi_s),
        .sdo_bit(sdo_bit), .cap(cap), .rise_cnt(rise_cnt), .fall_cnt(fall_cnt)
    );

    // Next-state and transition strobes
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        load    = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_CONV: begin
                if (finish) state_d = ST_SLEEP;          // conv_done
            end
            ST_SLEEP: begin
                if (cs_low) begin                        // select
                    state_d = ST_DOUT;
                    load    = 1'b1;
                end
            end
            ST_DOUT: begin
                if (cs_rise) begin                       // abort
                    state_d = ST_CONV;
                    start   = 1'b1;
                    commit  = (rise_cnt >= RISE_NEED) && (fall_cnt >= FALL_NEED);
                end else if (sck_fall && fall_cnt == LAST_FALL) begin  // word_end
                    state_d = ST_CONV;
                    start   = 1'b1;
                    commit  = (rise_cnt >= RISE_NEED);
                end
            end
            default: state_d = ST_CONV;
        endcase
    end

    // State and configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CONV;
            cfg_q   <= CFG_RESET;
        end else begin
            state_q <= state_d;
            if (commit) cfg_q <= cap;
        end
    end

    // Outputs
    always_comb begin
        sdo_oe  = cs_low;
        cfg_out = cfg_q;
        unique case (state_q)
            ST_CONV:  sdo = 1'b1;
            ST_SLEEP: sdo = 1'b0;
            ST_DOUT:  sdo = sdo_bit;
            default:  sdo = 1'b1;
        endcase
    end

endmodule

// File: rtl/adc_sp_checker.sv
module adc_sp_checker #(
    parameter int CFG_W = 13,
    parameter int CNT_W = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input adc_sp_pkg::sp_state_e state,
    input logic                  cs_low,
    input logic                  cs_rise,
    input logic [CNT_W-1:0]      fall_cnt,
    input logic [CFG_W-1:0]      cfg,
    input logic                  busy,
    input logic                  sdo,
    input logic                  sdo_oe
);
    import adc_sp_pkg::*;

    localparam logic [CNT_W-1:0] FALL_NEED = CNT_W'(CFG_W + 1);

    p_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |-> !sdo_oe);

    p_eoc_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && sdo_oe) |-> sdo);

    p_busy_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV) |-> busy);

    p_idle_notbusy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CONV) |-> !busy);

    p_ready_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOUT && fall_cnt == '0) |-> !sdo);

    p_abort_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOUT && cs_rise) |=> (state == ST_CONV && busy));

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DOUT) |=> $stable(cfg));

    p_keep_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOUT && cs_rise && fall_cnt < FALL_NEED) |=> $stable(cfg));

    p_order_conv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV) |=> (state != ST_DOUT));

    p_order_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |=> (state != ST_CONV));

endmodule

bind adc_serial_port adc_sp_checker #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .cs_low(cs_low),
    .cs_rise(cs_rise), .fall_cnt(fall_cnt), .cfg(cfg_q), .busy(busy),
    .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/adc_serial_port_bench.sv
module adc_serial_port_bench;

    localparam int CONV = 40;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic [29:0] conv_data = 30'h2ABC_1234;
    logic        sdo, sdo_oe, busy;
    logic [12:0] cfg_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [29:0] VAL_A = 30'h2ABC_1234;
    localparam logic [29:0] VAL_B = 30'h1555_5555;
    localparam logic [29:0] VAL_C = 30'h3000_00F1;
    localparam logic [12:0] CFG_X = 13'h1A5B;
    localparam logic [12:0] CFG_Y = 13'h0F0F;
    localparam logic [12:0] CFG_Z = 13'h1234;
    localparam logic [12:0] CFG_W = 13'h0ABC;

    always #10 clk = ~clk;

    adc_serial_port #(.CONV_CYCLES(CONV)) u_adc_serial_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .conv_data(conv_data), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy),
        .cfg_out(cfg_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int g = 0; g < 1000 && busy; g++) @(negedge clk);
    endtask

    // Clock n bits; got[31-i] holds the bit seen after i falling edges
    task automatic read_bits(input int n, input logic [12:0] cfgv,
                             input bit already_low, output logic [31:0] got);
        got = '0;
        if (!already_low) begin
            cs_n = 1'b0;
            wait_clk(8);
        end
        for (int i = 0; i < n; i++) begin
            got[31-i] = sdo;
            sdi = (i < 13) ? cfgv[12-i] : 1'b0;
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
            wait_clk(HALF);
        end
    endtask

    task automatic measure_busy(output int cyc);
        cyc = 0;
        for (int g = 0; g < 50 && !busy; g++) @(negedge clk);
        while (busy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        wait_clk(1);
        chk("R1 busy at reset", busy, 1);
        chk("R1 oe at reset", sdo_oe, 0);
        chk("R1 cfg at reset", cfg_out, 0);
        rst_n = 1'b1;
        wait_clk(2);
        chk("R2 oe low with cs high", sdo_oe, 0);
    endtask

    task automatic t_poll();
        cs_n = 1'b0;
        wait_clk(6);
        chk("R2 oe high with cs low", sdo_oe, 1);
        chk("R3 busy flag on sdo", sdo, 1);
        cs_n = 1'b1;
        wait_clk(6);
        chk("R2 oe drops with cs", sdo_oe, 0);
    endtask

    task automatic t_full_read();
        logic [31:0] w;
        wait_ready();
        conv_data = VAL_B;
        wait_clk(30);
        chk("R9 waits in sleep, not busy", busy, 0);
        read_bits(32, CFG_X, 1'b0, w);
        chk("R4 R9 full word", w, {2'b00, VAL_A});
        chk("R8 sdo busy after word end", sdo, 1);
        chk("R8 busy after word end", busy, 1);
        cs_n = 1'b1;
        wait_clk(6);
        chk("R6 R8 cfg committed", cfg_out, CFG_X);
    endtask

    task automatic t_abort5();
        logic [31:0] w;
        int cyc;
        wait_ready();
        read_bits(5, CFG_Y, 1'b0, w);
        chk("R4 top five bits", w[31:27], VAL_B[29:27] | 5'b00000);
        cs_n = 1'b1;
        measure_busy(cyc);
        chk("R5 R3 busy period after abort", cyc, CONV);
        chk("R7 cfg kept after 5 bits", cfg_out, CFG_X);
    endtask

    task automatic t_abort13();
        logic [31:0] w;
        wait_ready();
        read_bits(13, CFG_Z, 1'b0, w);
        cs_n = 1'b1;
        wait_clk(8);
        chk("R5 busy after abort at 13", busy, 1);
        chk("R7 cfg kept after 13 bits", cfg_out, CFG_X);
    endtask

    task automatic t_abort14();
        logic [31:0] w;
        wait_ready();
        read_bits(14, CFG_Z, 1'b0, w);
        cs_n = 1'b1;
        wait_clk(8);
        chk("R6 cfg committed after 14 bits", cfg_out, CFG_Z);
        conv_data = VAL_C;
    endtask

    task automatic t_poll_read();
        logic [31:0] w;
        cs_n = 1'b0;
        wait_clk(8);
        chk("R3 polled busy flag", sdo, 1);
        wait_ready();
        wait_clk(8);
        chk("R9 ready flag while polling", sdo, 0);
        read_bits(32, CFG_W, 1'b1, w);
        chk("R4 word after polling", w, {2'b00, VAL_C});
        cs_n = 1'b1;
        wait_clk(6);
        chk("R6 cfg after polled read", cfg_out, CFG_W);
    endtask

    initial begin
        t_reset();
        t_poll();
        t_full_read();
        t_abort5();
        t_abort13();
        t_abort14();
        t_poll_read();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule